// File: doc/BRIEF.md
# Glitch-free system clock selector

This block picks which of three source clocks drives the system clock. The sources are an internal RC oscillator, an external crystal oscillator and a PLL output. Software writes a 2-bit select field, and the block moves to the new source without producing a shortened or merged pulse. A 2-bit status field reports the source that is actually driving the output. This field trails the select field until the handover has finished.

Hardware can take the choice away from software. On a low-power-exit pulse, or while the crystal-failure flag is high, the select field is forced back to the internal oscillator code, and the block then hands the output back to that oscillator.

A switch starts only once the target source reports ready. Until then the request stays pending and the output keeps its current source. A handover has two phases. The old source's gate closes on a falling edge of the old clock, after the request has crossed into that clock's domain. The new gate opens on a falling edge of the new clock, after the request has passed through a chain of synchronizer flops clocked by the new clock.

Top module: `sysclk_mux`

## Requirements
- R1: After reset, both the select field and the status field read 01, and `sys_clk` runs at the internal oscillator's period.
- R2: A write of code 01 (internal), 10 (crystal) or 11 (PLL) with no hardware force active loads the select field at the next control clock edge.
- R3: A write of the reserved code 00 leaves the select field unchanged, and the status and output source are unchanged too.
- R4: Once a handover completes, the status field equals the select field, and `sys_clk` has the period of the selected source.
- R5: The status field keeps the old code while a handover is in progress. If the target's ready flag is low, the request stays pending with status and output unchanged. It completes once ready rises.
- R6: At most one source gate is ever open. Every high pulse on `sys_clk` is a full high phase of one source, so no runt pulse appears.
- R7: A `lp_exit` pulse sets the select field to 01 at the next control clock edge. The output then hands over to the internal oscillator.
- R8: While `xtal_fail` is high, the select field is forced to 01 at the next control clock edge, and the output returns to the internal oscillator.
- R9: When a hardware force and a software write arrive in the same cycle, the force wins and the select field becomes 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock for the select register and the handover controller |
| rst_n | input | 1 | Active-low asynchronous reset |
| irc_clk | input | 1 | Internal RC oscillator clock |
| xtal_clk | input | 1 | External crystal oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| irc_rdy | input | 1 | Internal oscillator ready (asynchronous) |
| xtal_rdy | input | 1 | Crystal oscillator ready (asynchronous) |
| pll_rdy | input | 1 | PLL locked/ready (asynchronous) |
| lp_exit | input | 1 | One-cycle pulse on exit from stop or standby, synchronous to `ctl_clk` |
| xtal_fail | input | 1 | Crystal failure flag, synchronous to `ctl_clk` |
| wr_en | input | 1 | Select field write strobe |
| wr_sel | input | 2 | Select code to write |
| sel_q | output | 2 | Current select field |
| stat_q | output | 2 | Source actually driving `sys_clk` |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The assertions assume several things about the inputs. `lp_exit`, `xtal_fail` and the write port are synchronous to `ctl_clk`. Every source clock keeps toggling while its gate is being closed or opened, because a handover waits for edges of both clocks. A source's ready flag does not fall while a handover to that source is under way. The stimulus meets these assumptions. It changes control inputs only on falling edges of `ctl_clk`, keeps all three source clocks running for the whole run, and raises the PLL ready flag only while a request to the PLL is pending.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   localparam int NSRC = 3;
   localparam int CW   = 2;

   typedef logic [CW-1:0] src_code_t;

   localparam src_code_t CODE_RSVD = 2'b00;
   localparam src_code_t CODE_IRC  = 2'b01;
   localparam src_code_t CODE_XTAL = 2'b10;
   localparam src_code_t CODE_PLL  = 2'b11;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_CLOSE = 2'd1,
      HS_OPEN  = 2'd2
   } hs_state_t;

   // code n (1..3) maps to gate index n-1; the reserved code maps to none
   function automatic logic [NSRC-1:0] code2hot(input src_code_t c);
      logic [NSRC-1:0] h;
      h = '0;
      for (int i = 0; i < NSRC; i++)
         if (c == src_code_t'(i + 1)) h[i] = 1'b1;
      return h;
   endfunction
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sysclk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sysclk_gate_cell.sv
module sysclk_gate_cell #(
   parameter int STAGES      = 2,
   parameter bit ON_AT_RESET = 1'b0
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic en_req,
   output logic gclk,
   output logic en_live
);
   logic en_s;
   logic en_ng;

   // request crosses into the source domain on rising edges
   sysclk_sync #(.STAGES(STAGES), .RST_VAL(ON_AT_RESET)) u_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (en_req),
      .q     (en_s)
   );

   // enable only changes while the source clock is low
   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n) en_ng <= ON_AT_RESET;
      else        en_ng <= en_s;
   end

   assign gclk    = clk_src & en_ng;
   assign en_live = en_ng;
endmodule

// File: rtl/sysclk_sel_reg.sv
module sysclk_sel_reg
   import sysclk_pkg::*;
(
   input  logic      ctl_clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  src_code_t wr_sel,
   input  logic      lp_exit,
   input  logic      xtal_fail,
   output src_code_t sel
);
   logic force_irc;
   assign force_irc = lp_exit | xtal_fail;

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n)                            sel <= CODE_IRC;
      else if (force_irc)                    sel <= CODE_IRC;
      else if (wr_en && wr_sel != CODE_RSVD) sel <= wr_sel;
   end

   p_write_load_r2: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (wr_en && wr_sel != CODE_RSVD && !force_irc) |=> sel == $past(wr_sel));

   p_reserved_ignored_r3: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (wr_en && wr_sel == CODE_RSVD && !force_irc) |=> $stable(sel));

   p_lp_exit_force_r7: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      lp_exit |=> sel == CODE_IRC);

   p_xtal_fail_force_r8: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      xtal_fail |=> sel == CODE_IRC);

   p_force_beats_write_r9: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (wr_en && force_irc) |=> sel == CODE_IRC);
endmodule

// File: rtl/sysclk_switch_ctl.sv
module sysclk_switch_ctl
   import sysclk_pkg::*;
(
   input  logic            ctl_clk,
   input  logic            rst_n,
   input  src_code_t       sel,
   input  logic [NSRC-1:0] rdy_s,
   input  logic [NSRC-1:0] ack,
   output logic [NSRC-1:0] en_req,
   output src_code_t       stat
);
   hs_state_t st;
   src_code_t tgt;

   logic [NSRC-1:0] sel_hot, stat_hot, tgt_hot;
   logic            want, tgt_ready;

   assign sel_hot   = code2hot(sel);
   assign stat_hot  = code2hot(stat);
   assign tgt_hot   = code2hot(tgt);
   assign want      = (sel != stat);
   assign tgt_ready = |(sel_hot & rdy_s);

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= HS_IDLE;
         stat   <= CODE_IRC;
         tgt    <= CODE_IRC;
         en_req <= code2hot(CODE_IRC);
      end else begin
         unique case (st)
            HS_IDLE: if (want && tgt_ready) begin
               tgt    <= sel;
               en_req <= en_req & ~stat_hot;
               st     <= HS_CLOSE;
            end
            HS_CLOSE: if (!(|(ack & stat_hot))) begin
               en_req <= tgt_hot;
               st     <= HS_OPEN;
            end
            HS_OPEN: if (|(ack & tgt_hot)) begin
               stat <= tgt;
               st   <= HS_IDLE;
            end
            default: st <= HS_IDLE;
         endcase
      end
   end

   p_single_request_r6: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(en_req));

   p_single_live_gate_r6: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(ack));

   p_status_needs_gate_r4: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      !$stable(stat) |-> |(ack & code2hot(stat)));

   p_status_legal_r4: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      stat != CODE_RSVD);

   p_pending_holds_r5: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (st == HS_IDLE && want && !tgt_ready) |=> $stable(stat));
endmodule

// File: rtl/sysclk_mux.sv
module sysclk_mux
   import sysclk_pkg::*;
#(
   parameter int GATE_STAGES = 2,
   parameter int RDY_STAGES  = 2,
   parameter int ACK_STAGES  = 2
) (
   input  logic       ctl_clk,
   input  logic       rst_n,
   input  logic       irc_clk,
   input  logic       xtal_clk,
   input  logic       pll_clk,
   input  logic       irc_rdy,
   input  logic       xtal_rdy,
   input  logic       pll_rdy,
   input  logic       lp_exit,
   input  logic       xtal_fail,
   input  logic       wr_en,
   input  logic [1:0] wr_sel,
   output logic [1:0] sel_q,
   output logic [1:0] stat_q,
   output logic       sys_clk
);
   generate
      if (GATE_STAGES < 2) begin : g_bad_gate
         $error("sysclk_mux: GATE_STAGES must be at least 2");
      end
      if (RDY_STAGES < 2) begin : g_bad_rdy
         $error("sysclk_mux: RDY_STAGES must be at least 2");
      end
      if (ACK_STAGES < 2) begin : g_bad_ack
         $error("sysclk_mux: ACK_STAGES must be at least 2");
      end
   endgenerate

   localparam logic [NSRC-1:0] RST_HOT = code2hot(CODE_IRC);

   logic [NSRC-1:0] src_clk, rdy_raw, rdy_s, en_req, en_live, ack, gclk;
   src_code_t       sel, stat;

   assign src_clk = {pll_clk, xtal_clk, irc_clk};
   assign rdy_raw = {pll_rdy, xtal_rdy, irc_rdy};

   sysclk_sel_reg u_sel (
      .ctl_clk   (ctl_clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .lp_exit   (lp_exit),
      .xtal_fail (xtal_fail),
      .sel       (sel)
   );

   sysclk_switch_ctl u_ctl (
      .ctl_clk (ctl_clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .rdy_s   (rdy_s),
      .ack     (ack),
      .en_req  (en_req),
      .stat    (stat)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      sysclk_sync #(.STAGES(RDY_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
         .clk   (ctl_clk),
         .rst_n (rst_n),
         .d     (rdy_raw[i]),
         .q     (rdy_s[i])
      );

      sysclk_gate_cell #(.STAGES(GATE_STAGES), .ON_AT_RESET(RST_HOT[i])) u_gate (
         .clk_src (src_clk[i]),
         .rst_n   (rst_n),
         .en_req  (en_req[i]),
         .gclk    (gclk[i]),
         .en_live (en_live[i])
      );

      sysclk_sync #(.STAGES(ACK_STAGES), .RST_VAL(RST_HOT[i])) u_ack_sync (
         .clk   (ctl_clk),
         .rst_n (rst_n),
         .d     (en_live[i]),
         .q     (ack[i])
      );
   end

   assign sys_clk = |gclk;
   assign sel_q   = sel;
   assign stat_q  = stat;
endmodule

// File: tb/sysclk_mux_test.sv
`timescale 1ns/1ps
module sysclk_mux_test;
   logic       ctl_clk = 0, irc_clk = 0, xtal_clk = 0, pll_clk = 0;
   logic       rst_n = 0;
   logic       irc_rdy = 1, xtal_rdy = 1, pll_rdy = 0;
   logic       lp_exit = 0, xtal_fail = 0, wr_en = 0;
   logic [1:0] wr_sel = 0;
   logic [1:0] sel_q, stat_q;
   logic       sys_clk;

   localparam real P_IRC = 7.0, P_XTAL = 11.0, P_PLL = 4.0;

   always #2.5 ctl_clk  = ~ctl_clk;
   always #3.5 irc_clk  = ~irc_clk;
   always #5.5 xtal_clk = ~xtal_clk;
   always #2.0 pll_clk  = ~pll_clk;

   sysclk_mux uut (
      .ctl_clk(ctl_clk), .rst_n(rst_n),
      .irc_clk(irc_clk), .xtal_clk(xtal_clk), .pll_clk(pll_clk),
      .irc_rdy(irc_rdy), .xtal_rdy(xtal_rdy), .pll_rdy(pll_rdy),
      .lp_exit(lp_exit), .xtal_fail(xtal_fail),
      .wr_en(wr_en), .wr_sel(wr_sel),
      .sel_q(sel_q), .stat_q(stat_q), .sys_clk(sys_clk)
   );

   int checks = 0, failures = 0;
   bit finished = 0;

   typedef struct {
      string      req;
      logic [1:0] esel;
      logic [1:0] estat;
      int         settle;
      real        eper;
   } exp_t;

   exp_t q[$];
   event consumed;

   // scoreboard monitor: pops expected items and compares at the ports
   initial begin
      forever begin
         exp_t e;
         real  t0, d;
         wait (q.size() > 0);
         e = q.pop_front();
         repeat (e.settle) @(posedge ctl_clk);
         @(negedge ctl_clk);
         checks++;
         if (sel_q !== e.esel) begin
            failures++;
            $display("FAIL %s: sel_q=%0d expected %0d", e.req, sel_q, e.esel);
         end
         checks++;
         if (stat_q !== e.estat) begin
            failures++;
            $display("FAIL %s: stat_q=%0d expected %0d", e.req, stat_q, e.estat);
         end
         if (e.eper > 0.0) begin
            @(posedge sys_clk);
            t0 = $realtime;
            @(posedge sys_clk);
            d = $realtime - t0;
            checks++;
            if (d < e.eper - 0.01 || d > e.eper + 0.01) begin
               failures++;
               $display("FAIL %s: sys_clk period=%0.2f expected %0.2f", e.req, d, e.eper);
            end
         end
         ->consumed;
      end
   end

   // runt detector: every high phase must be a full source half period
   real rise_t = 0.0;
   int  runts = 0;
   always @(posedge sys_clk) rise_t = $realtime;
   always @(negedge sys_clk) if (rst_n && ($realtime - rise_t) < 1.9) runts++;

   task automatic push_exp(string req, logic [1:0] es, logic [1:0] et, int settle, real per);
      exp_t e;
      e = '{req, es, et, settle, per};
      q.push_back(e);
      @(consumed);
   endtask

   task automatic do_write(logic [1:0] code);
      @(negedge ctl_clk);
      wr_en  = 1;
      wr_sel = code;
      @(negedge ctl_clk);
      wr_en  = 0;
   endtask

   task automatic pulse_lp_exit();
      @(negedge ctl_clk);
      lp_exit = 1;
      @(negedge ctl_clk);
      lp_exit = 0;
   endtask

   initial begin
      repeat (10) @(negedge ctl_clk);
      rst_n = 1;

      // R1: reset state
      push_exp("R1", 2'b01, 2'b01, 2, P_IRC);

      // R3: reserved code ignored from internal
      do_write(2'b00);
      push_exp("R3", 2'b01, 2'b01, 0, 0.0);

      // R2 + R5 lag: select crystal, status still internal shortly after
      do_write(2'b10);
      push_exp("R5", 2'b10, 2'b01, 0, 0.0);
      // R4: completion on crystal
      push_exp("R4", 2'b10, 2'b10, 60, P_XTAL);

      // R5: PLL not ready, request stays pending
      do_write(2'b11);
      push_exp("R2", 2'b11, 2'b10, 0, 0.0);
      push_exp("R5", 2'b11, 2'b10, 60, P_XTAL);
      @(negedge ctl_clk);
      pll_rdy = 1;
      push_exp("R5", 2'b11, 2'b11, 60, P_PLL);

      // R3: reserved code ignored while on PLL
      do_write(2'b00);
      push_exp("R3", 2'b11, 2'b11, 20, P_PLL);

      // R7: low-power exit forces internal
      pulse_lp_exit();
      push_exp("R7", 2'b01, 2'b11, 0, 0.0);
      push_exp("R7", 2'b01, 2'b01, 60, P_IRC);

      // R8: crystal failure forces internal
      do_write(2'b10);
      push_exp("R4", 2'b10, 2'b10, 60, P_XTAL);
      @(negedge ctl_clk);
      xtal_fail = 1;
      @(negedge ctl_clk);
      push_exp("R8", 2'b01, 2'b10, 0, 0.0);
      xtal_fail = 0;
      push_exp("R8", 2'b01, 2'b01, 60, P_IRC);

      // R9: force and write in the same cycle
      @(negedge ctl_clk);
      wr_en = 1; wr_sel = 2'b11; lp_exit = 1;
      @(negedge ctl_clk);
      wr_en = 0; lp_exit = 0;
      push_exp("R9", 2'b01, 2'b01, 60, P_IRC);

      // R2: direct internal to PLL
      do_write(2'b11);
      push_exp("R2", 2'b11, 2'b11, 60, P_PLL);

      // R6: no runt high pulse during all handovers
      checks++;
      if (runts != 0) begin
         failures++;
         $display("FAIL R6: runt pulses=%0d expected 0", runts);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule